// File: doc/BRIEF.md
# Hall-Sensor Commutation and Gate Sequencer

This block turns three digital Hall-sensor levels into six gate enables for a three-phase brushless motor bridge. There are three high-side and three low-side enables. In 120-degree conduction the block picks one phase whose high-side switch stays on and one phase whose low-side switch is chopped by an internal PWM carrier. During the chop's off-time it turns on the high-side switch of the chopped phase, which gives synchronous rectification. Every switch-over inside a phase passes through an enforced dead time.

Four controls override normal running. Stop turns every gate off. Brake turns all low sides on and all high sides off, a short brake. An all-equal Hall code turns every gate off. A change of direction while running forces a short all-off pause. A current-limit pulse ends the low-side on-time for the rest of the current carrier period, except during braking. The duty word is an input. The carrier period and the dead time are parameters in clock cycles.

The control state machine has five states:
- ST_IDLE: stop asserted, or just out of reset.
- ST_BRAKE: short brake.
- ST_FAULT: invalid Hall code.
- ST_RUN: normal commutation.
- ST_REVERSE: the direction-change pause, lasting DEAD_CYC cycles.

The transitions are tested in this order:
1. Stop goes to ST_IDLE from any state.
2. Otherwise brake goes to ST_BRAKE.
3. Otherwise an invalid Hall code goes to ST_FAULT.
4. Otherwise a direction flip seen in ST_RUN goes to ST_REVERSE.
5. Otherwise ST_REVERSE counts out its pause.
6. Everything else goes to ST_RUN.

Each phase has its own gate state machine with states PH_OFF, PH_HI and PH_LO:
- PH_HI or PH_LO returns to PH_OFF as soon as its request drops.
- PH_OFF counts its age and leaves only when the age has reached DEAD_CYC.

Top module: `bldc_gate_sequencer`

## Requirements
- R1: With forward direction (`dir_rev_i`=0) in running, the Hall codes `hall_i[2:0]` select a step and drive pair (phase index U=bit0, V=bit1, W=bit2) as follows:

  | Step | Hall code | High-side phase | Low-side phase |
  |---|---|---|---|
  | 1 | 101 | V | U |
  | 2 | 100 | W | U |
  | 3 | 110 | W | V |
  | 4 | 010 | U | V |
  | 5 | 011 | U | W |
  | 6 | 001 | V | W |

  The selected high-side gate is held on continuously.
- R2: With `dir_rev_i`=1 the high-side and low-side phase of every step are swapped.
- R3: Hall codes 000 and 111 turn all six gates off. Two clock edges after the code appears (with stop and brake low), all outputs are off.
- R4: `stop_i`=1 turns all six gates off. It overrides brake and the Hall inputs.
- R5: `brake_i`=1 with `stop_i`=0 turns every high-side gate off and, once the dead time has elapsed, every low-side gate on. This holds whatever the duty and the Hall code.
- R6: `ilim_i` has no effect while in the brake state. The low-side gates stay on.
- R7: Outside braking, an `ilim_i` pulse clears the PWM on-level from the next cycle until the carrier wraps. The pulse is ignored on the carrier's last count.
- R8: The chopped low-side gate is requested while the carrier count (0 to PERIOD_CYC-1) is below `duty_i`. A duty of 0 never requests it. A duty of PERIOD_CYC requests it for the whole period.
- R9: While the chopped low side is not requested, the high side of that same phase is requested (synchronous rectification).
- R10: A phase never has both gates on. After a phase's gate turns off, neither gate of that phase turns on for at least DEAD_CYC+1 cycles.
- R11: A flip of `dir_rev_i` seen while running removes all gate requests for DEAD_CYC cycles before running resumes with the new direction.
- R12: While `rst_n` is low all gates are off. After release, no gate turns on before DEAD_CYC+1 edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hall_i | input | 3 | digital Hall levels, bit0 sensor 1 |
| dir_rev_i | input | 1 | 0 forward, 1 reverse |
| stop_i | input | 1 | 1 stop (all off), 0 run |
| brake_i | input | 1 | 1 short brake, 0 release |
| duty_i | input | DUTY_W | PWM on-count per carrier period |
| ilim_i | input | 1 | current-limit event |
| gate_hi_o | output | 3 | high-side gate enables U,V,W |
| gate_lo_o | output | 3 | low-side gate enables U,V,W |

## Verification
The bench builds the block with PERIOD_CYC=16 and DEAD_CYC=2. At these values a carrier period fits within a few dozen cycles, so each Hall step spans several wraps, current-limit clipping and its release at the wrap both appear, and the duty end points 0 and 16 can be driven. The short dead time is still long enough, compared with the chopped on-times, to show gates whose request is cut short by the dead time, and to show the direction-change pause adding to the per-phase dead time.

// File: rtl/bldc_gate_pkg.sv
package bldc_gate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_BRAKE,
        ST_FAULT,
        ST_REVERSE
    } ctrl_state_e;

    typedef enum logic [1:0] {
        PH_OFF,
        PH_HI,
        PH_LO
    } phase_state_e;

    // step (1..6) -> {high-side phase index, low-side phase index}
    function automatic logic [3:0] step_pair(input logic [2:0] step);
        logic [3:0] pair;
        case (step)
            3'd1:    pair = {2'd1, 2'd0};
            3'd2:    pair = {2'd2, 2'd0};
            3'd3:    pair = {2'd2, 2'd1};
            3'd4:    pair = {2'd0, 2'd1};
            3'd5:    pair = {2'd0, 2'd2};
            3'd6:    pair = {2'd1, 2'd2};
            default: pair = 4'd0;
        endcase
        return pair;
    endfunction

endpackage

// File: rtl/hall_step_decoder.sv
module hall_step_decoder #(
    parameter logic [17:0] STEP_CODES = {3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101}
) (
    input  logic [2:0] hall_i,
    output logic [2:0] step_o
);
    // step k (1..6) matches STEP_CODES[3(k-1) +: 3]; no match gives 0
    always_comb begin
        step_o = 3'd0;
        for (int k = 0; k < 6; k++) begin
            if (hall_i == STEP_CODES[3*k +: 3]) step_o = 3'(k + 1);
        end
    end
endmodule

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
    parameter int PERIOD_CYC = 3906,
    localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1,
    localparam int DW = $clog2(PERIOD_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] duty_i,
    input  logic          ilim_i,
    input  logic          braking_i,
    output logic          pwm_on_o
);
    logic [CW-1:0] count_q;
    logic          clip_q;
    logic          wrap;

    assign wrap = (count_q == CW'(PERIOD_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            clip_q  <= 1'b0;
        end else begin
            count_q <= wrap ? '0 : count_q + 1'b1;
            if (wrap)
                clip_q <= 1'b0;
            else if (ilim_i && !braking_i)
                clip_q <= 1'b1;
        end
    end

    assign pwm_on_o = (DW'(count_q) < duty_i) && !clip_q;
endmodule

// File: rtl/phase_deadband.sv
module phase_deadband
    import bldc_gate_pkg::*;
#(
    parameter int DEAD_CYC = 500,
    localparam int AW = $clog2(DEAD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_req_i,
    input  logic lo_req_i,
    output logic hi_o,
    output logic lo_o
);
    phase_state_e state_q, state_d;
    logic [AW-1:0] age_q, age_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            age_q   <= age_d;
        end
    end

    always_comb begin
        state_d = state_q;
        age_d   = age_q;
        unique case (state_q)
            PH_OFF: begin
                if (age_q == AW'(DEAD_CYC)) begin
                    if (hi_req_i)      state_d = PH_HI;
                    else if (lo_req_i) state_d = PH_LO;
                end else begin
                    age_d = age_q + 1'b1;
                end
            end
            PH_HI: if (!hi_req_i) begin
                state_d = PH_OFF;
                age_d   = '0;
            end
            PH_LO: if (!lo_req_i) begin
                state_d = PH_OFF;
                age_d   = '0;
            end
            default: begin
                state_d = PH_OFF;
                age_d   = '0;
            end
        endcase
    end

    assign hi_o = (state_q == PH_HI);
    assign lo_o = (state_q == PH_LO);
endmodule

// File: rtl/bldc_gate_sequencer.sv
module bldc_gate_sequencer
    import bldc_gate_pkg::*;
#(
    parameter int          PERIOD_CYC = 3906,
    parameter int          DEAD_CYC   = 500,
    parameter logic [17:0] STEP_CODES = {3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101},
    localparam int         DUTY_W     = $clog2(PERIOD_CYC + 1),
    localparam int         GW         = $clog2(DEAD_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        hall_i,
    input  logic              dir_rev_i,
    input  logic              stop_i,
    input  logic              brake_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              ilim_i,
    output logic [2:0]        gate_hi_o,
    output logic [2:0]        gate_lo_o
);
    ctrl_state_e st_q, st_d;
    logic [GW-1:0] gap_q, gap_d;
    logic          dir_q;
    logic [2:0]    step;
    logic          pwm_on;
    logic [2:0]    hi_req, lo_req;
    logic [1:0]    hi_ph, lo_ph;

    hall_step_decoder #(.STEP_CODES(STEP_CODES)) u_dec (
        .hall_i (hall_i),
        .step_o (step)
    );

    pwm_carrier #(.PERIOD_CYC(PERIOD_CYC)) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .duty_i    (duty_i),
        .ilim_i    (ilim_i),
        .braking_i (st_q == ST_BRAKE),
        .pwm_on_o  (pwm_on)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            gap_q <= '0;
            dir_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            gap_q <= gap_d;
            dir_q <= dir_rev_i;
        end
    end

    // next-state logic, priority: stop, brake, invalid Hall, direction flip
    always_comb begin
        st_d  = ST_RUN;
        gap_d = '0;
        if (stop_i)
            st_d = ST_IDLE;
        else if (brake_i)
            st_d = ST_BRAKE;
        else if (step == 3'd0)
            st_d = ST_FAULT;
        else if (st_q == ST_RUN && dir_rev_i != dir_q)
            st_d = ST_REVERSE;
        else if (st_q == ST_REVERSE && gap_q != GW'(DEAD_CYC - 1)) begin
            st_d  = ST_REVERSE;
            gap_d = gap_q + 1'b1;
        end
    end

    // output requests per state
    always_comb begin
        hi_req = '0;
        lo_req = '0;
        {hi_ph, lo_ph} = step_pair(step);
        if (dir_rev_i) {hi_ph, lo_ph} = {lo_ph, hi_ph};
        unique case (st_q)
            ST_RUN: if (step != 3'd0) begin
                hi_req[hi_ph] = 1'b1;
                lo_req[lo_ph] = pwm_on;
                hi_req[lo_ph] = !pwm_on;
            end
            ST_BRAKE: lo_req = 3'b111;
            ST_IDLE, ST_FAULT, ST_REVERSE: ;
            default: ;
        endcase
    end

    for (genvar p = 0; p < 3; p++) begin : g_phase
        phase_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
            .clk      (clk),
            .rst_n    (rst_n),
            .hi_req_i (hi_req[p]),
            .lo_req_i (lo_req[p]),
            .hi_o     (gate_hi_o[p]),
            .lo_o     (gate_lo_o[p])
        );
    end
endmodule

// File: rtl/bldc_gate_checker.sv
module bldc_gate_checker #(
    parameter int DEAD_CYC = 500,
    localparam int OW = $clog2(DEAD_CYC + 2)
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_i,
    input logic       stop_i,
    input logic       brake_i,
    input logic       ilim_i,
    input logic [2:0] gate_hi_o,
    input logic [2:0] gate_lo_o
);
    logic hall_bad;
    assign hall_bad = (hall_i == 3'b000) || (hall_i == 3'b111);

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi_o & gate_lo_o) == 3'b000); // R10

    AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && $past(stop_i) |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000)); // R4

    AST_BRAKE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_i && !stop_i) && $past(brake_i && !stop_i) |=> gate_hi_o == 3'b000); // R5

    AST_BRAKE_IGNORES_ILIM: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_i && !stop_i) && $past(brake_i && !stop_i) && ilim_i && gate_lo_o == 3'b111
        |=> gate_lo_o == 3'b111); // R6

    AST_INVALID_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_bad && !stop_i && !brake_i) && $past(hall_bad && !stop_i && !brake_i)
        |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000)); // R3

    for (genvar p = 0; p < 3; p++) begin : g_gap
        logic [OW-1:0] off_cnt;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                off_cnt <= '0;
            else if (gate_hi_o[p] || gate_lo_o[p])
                off_cnt <= '0;
            else if (off_cnt != OW'(DEAD_CYC + 1))
                off_cnt <= off_cnt + 1'b1;
        end
        AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi_o[p] || gate_lo_o[p]) |-> off_cnt >= OW'(DEAD_CYC + 1)); // R10
    end
endmodule

bind bldc_gate_sequencer bldc_gate_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_i    (hall_i),
    .stop_i    (stop_i),
    .brake_i   (brake_i),
    .ilim_i    (ilim_i),
    .gate_hi_o (gate_hi_o),
    .gate_lo_o (gate_lo_o)
);

// File: tb/sim_bldc_gate_sequencer.sv
`timescale 1ns/1ps
module sim_bldc_gate_sequencer;
    localparam int PER  = 16;
    localparam int DEAD = 2;
    localparam int DW   = $clog2(PER + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    hall = 3'b101;
    logic          dir = 1'b0;
    logic          stop = 1'b1;
    logic          brake = 1'b1;
    logic [DW-1:0] duty = DW'(8);
    logic          ilim = 1'b0;
    logic [2:0]    ghi, glo;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    string tag = "R12";

    always #2 clk = ~clk;

    bldc_gate_sequencer #(.PERIOD_CYC(PER), .DEAD_CYC(DEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_rev_i(dir),
        .stop_i(stop), .brake_i(brake), .duty_i(duty), .ilim_i(ilim),
        .gate_hi_o(ghi), .gate_lo_o(glo)
    );

    // reference model built from the requirement tables
    int codes [6] = '{5, 4, 6, 2, 3, 1};
    int hi_of [7] = '{0, 1, 2, 2, 0, 0, 1};
    int lo_of [7] = '{0, 0, 0, 1, 1, 2, 2};
    int m_mode = 0;   // 0 idle, 1 run, 2 brake, 3 fault, 4 pause
    int m_gap = 0, m_dirq = 0, m_cnt = 0, m_clip = 0;
    int m_ph [3] = '{0, 0, 0};  // 0 off, 1 high on, 2 low on
    int m_age [3] = '{0, 0, 0};
    logic [2:0] e_hi, e_lo;

    always_comb begin
        for (int p = 0; p < 3; p++) begin
            e_hi[p] = (m_ph[p] == 1);
            e_lo[p] = (m_ph[p] == 2);
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            int s, hp, lp, t;
            bit pon;
            bit rh [3];
            bit rl [3];
            s = 0;
            for (int k = 0; k < 6; k++) if (int'(hall) == codes[k]) s = k + 1;
            pon = (m_cnt < int'(duty)) && (m_clip == 0);
            for (int p = 0; p < 3; p++) begin rh[p] = 0; rl[p] = 0; end
            if (m_mode == 1 && s != 0) begin
                hp = hi_of[s]; lp = lo_of[s];
                if (dir) begin t = hp; hp = lp; lp = t; end
                rh[hp] = 1; rl[lp] = pon; rh[lp] = !pon;
            end else if (m_mode == 2) begin
                for (int p = 0; p < 3; p++) rl[p] = 1;
            end
            for (int p = 0; p < 3; p++) begin
                if (m_ph[p] == 0) begin
                    if (m_age[p] == DEAD) begin
                        if (rh[p]) m_ph[p] = 1; else if (rl[p]) m_ph[p] = 2;
                    end else m_age[p]++;
                end else if ((m_ph[p] == 1 && !rh[p]) || (m_ph[p] == 2 && !rl[p])) begin
                    m_ph[p] = 0; m_age[p] = 0;
                end
            end
            if (m_cnt == PER - 1) m_clip = 0;
            else if (ilim && m_mode != 2) m_clip = 1;
            m_cnt = (m_cnt + 1) % PER;
            if (stop) begin m_mode = 0; m_gap = 0; end
            else if (brake) begin m_mode = 2; m_gap = 0; end
            else if (s == 0) begin m_mode = 3; m_gap = 0; end
            else if (m_mode == 1 && int'(dir) != m_dirq) begin m_mode = 4; m_gap = 0; end
            else if (m_mode == 4 && m_gap != DEAD - 1) m_gap++;
            else begin m_mode = 1; m_gap = 0; end
            m_dirq = int'(dir);
        end
    end

    task automatic check(string r, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gates hi,lo=%b expected %b at cycle %0d", r, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model, plus phase exclusivity
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(tag, {ghi, glo}, {e_hi, e_lo});
            if ((ghi & glo) != 3'b000) check("R10", {ghi, glo}, {ghi & ~glo, glo & ~ghi});
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, act=%0d exp=0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        hold(3);
        check("R12", {ghi, glo}, 6'b000000);  // reset state
        rst_n = 1'b1;
        hold(2);
        check("R12", {ghi, glo}, 6'b000000);  // no gate before dead time
        tag = "R4"; hold(10);
        check("R4", {ghi, glo}, 6'b000000);
        tag = "R5"; stop = 1'b0; hold(10);
        check("R5", {ghi, glo}, 6'b000111);
        tag = "R6"; ilim = 1'b1; hold(20);
        check("R6", {ghi, glo}, 6'b000111);
        ilim = 1'b0;
        brake = 1'b0;
        tag = "R1";
        for (int k = 0; k < 6; k++) begin hall = 3'(codes[k]); hold(40); end
        hall = 3'b101;
        tag = "R8"; duty = DW'(PER); hold(40);
        tag = "R9"; duty = DW'(0); hold(40);
        check("R9", {ghi, glo}, 6'b011000);   // step 1: V high held, U high rectifying
        tag = "R7"; duty = DW'(12);
        for (int k = 0; k < 5; k++) begin
            hold(3 + 5 * k); ilim = 1'b1; hold(1); ilim = 1'b0;
        end
        ilim = 1'b1; hold(40); ilim = 1'b0; hold(20);
        tag = "R11"; duty = DW'(8); dir = 1'b1; hold(10);
        tag = "R2";
        for (int k = 5; k >= 0; k--) begin hall = 3'(codes[k]); hold(40); end
        tag = "R11"; dir = 1'b0; hold(1); dir = 1'b1; hold(5); dir = 1'b0; hold(30);
        tag = "R3"; hall = 3'b000; hold(12);
        check("R3", {ghi, glo}, 6'b000000);
        hall = 3'b111; hold(12);
        check("R3", {ghi, glo}, 6'b000000);
        hall = 3'b100; tag = "R1"; hold(30);
        tag = "R4"; stop = 1'b1; brake = 1'b1; hold(10);
        check("R4", {ghi, glo}, 6'b000000);
        brake = 1'b0; hall = 3'b111; hold(10);
        check("R4", {ghi, glo}, 6'b000000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule